// File: doc/BRIEF.md
# Increment Stage with Stall Buffer

This block is one registered pipeline stage with a valid/ready handshake on each side. Every word it accepts passes through a combinational transform that adds one, modulo 2^16. The stage keeps the result in an output register that drives the downstream side. When that register is occupied and the downstream side is not taking it, a newly accepted result goes into a separate holding register.

While the holding register is occupied, the stage drops its upstream ready, so nothing is lost or overwritten. Once the downstream side takes the output word, the held word moves into the output register first. Upstream ready comes back in the same step, and from the next cycle input again flows straight to the output. With downstream ready held high, the stage passes one word per clock with no gaps.

Top module: `incr_skid_stage`

## Requirements
- R1: Reset is synchronous and active low on `rst_n`: after a clock edge that samples `rst_n` low, `out_valid` is 0 and `in_ready` is 1, and any held word is discarded.
- R2: A word moves across an interface only on a clock edge where valid and ready on that interface are both 1; an input presented while `in_ready` is 0 never reaches the output.
- R3: A word accepted while the output register is free (`out_valid` is 0, or `out_ready` is 1) appears one edge later with `out_valid` = 1 and `out_data` = `in_data` + 1.
- R4: The addition wraps modulo 2^16, so an input of 16'hFFFF yields 16'h0000.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change.
- R6: A word accepted while the output is held (`out_valid` 1, `out_ready` 0) goes into the holding register; after that edge `in_ready` is 0.
- R7: When `out_ready` is 1 while a word is held, the held value is in `out_data` with `out_valid` 1 after the next edge, and `in_ready` is 1 again.
- R8: On the cycle after a flush, an accepted input goes directly to the output as in R3.
- R9: With `out_ready` held at 1, `in_ready` stays 1 and each accepted word is on the output one cycle later, back to back.
- R10: When the output word is taken, `in_ready` is 1 and no input is valid, `out_valid` is 0 after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Upstream word is present |
| in_ready | output | 1 | Stage can accept a word this cycle |
| in_data | input | 16 | Upstream word |
| out_valid | output | 1 | Output register holds a word |
| out_ready | input | 1 | Downstream takes the output word this cycle |
| out_data | output | 16 | Incremented word |

## Verification
The assertions assume that `in_data`, `in_valid` and `out_ready` are settled, known values at every rising edge after reset. They also assume that upstream does not depend on `in_ready` rising in any particular cycle. The bench meets this by changing all inputs only on the falling edge and by starting with reset low and every input driven from time zero. Stall patterns are produced only by lowering `out_ready`, never by leaving inputs undefined.

// File: rtl/incr_stage_pkg.sv
// Package: shared types for the increment stage.
// Assumes nothing beyond a SystemVerilog-2017 compiler.
package incr_stage_pkg;

    // Where the output register takes its next value from in one cycle.
    typedef enum logic [1:0] {
        ROUTE_IDLE   = 2'd0,  // output register keeps or drains
        ROUTE_DIRECT = 2'd1,  // transformed input loads the output
        ROUTE_PARK   = 2'd2,  // transformed input loads the holding register
        ROUTE_FLUSH  = 2'd3   // holding register loads the output
    } route_e;

endpackage

// File: rtl/incr_stage_xform.sv
// Module: combinational transform, adds STEP to the input word.
// Assumes: wrap-around modulo 2^DATA_W is the wanted behaviour.
module incr_stage_xform #(
    parameter int DATA_W = 16,
    parameter int STEP   = 1
) (
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    localparam logic [DATA_W-1:0] STEP_V = DATA_W'(STEP);

    // Purpose: form the incremented word.
    always_comb begin
        dout = din + STEP_V;
    end

endmodule

// File: rtl/incr_stage_park_reg.sv
// Module: holding register used while the output is stalled.
// Assumes: the controller only loads it while it is empty, so the
// data needs no reset; emptiness is tracked by the controller.
module incr_stage_park_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    // Purpose: capture the transformed word on a parking cycle.
    always_ff @(posedge clk) begin
        if (load) begin
            dout <= din;
        end
    end

endmodule

// File: rtl/incr_stage_ctrl.sv
// Module: handshake controller. Picks the route for each cycle and
// keeps the flag that says the holding register is occupied.
// Assumes: out_valid is the registered output valid of the stage.
module incr_stage_ctrl
    import incr_stage_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   in_valid,
    input  logic   out_valid,
    input  logic   out_ready,
    output logic   in_ready,
    output route_e route
);

    logic park_full;
    logic out_free;

    // Purpose: output register can take a new word after this edge.
    always_comb begin
        out_free = !out_valid || out_ready;
    end

    // Purpose: choose the source of the next output / parking action.
    always_comb begin
        if (park_full) begin
            route = out_free ? ROUTE_FLUSH : ROUTE_IDLE;
        end else if (in_valid) begin
            route = out_free ? ROUTE_DIRECT : ROUTE_PARK;
        end else begin
            route = ROUTE_IDLE;
        end
    end

    // Purpose: track whether the holding register owns a word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            park_full <= 1'b0;
        end else if (route == ROUTE_PARK) begin
            park_full <= 1'b1;
        end else if (route == ROUTE_FLUSH) begin
            park_full <= 1'b0;
        end
    end

    // Purpose: refuse input while a parked word waits.
    always_comb begin
        in_ready = !park_full;
    end

endmodule

// File: rtl/incr_skid_stage.sv
// Module: top of the increment stage. Input word plus STEP goes to
// the output register, or to the holding register when the output
// is stalled; the held word is flushed before new input flows.
// Assumes: inputs are stable around the rising clock edge.
module incr_skid_stage
    import incr_stage_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int STEP   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);

    logic [DATA_W-1:0] result;
    logic [DATA_W-1:0] parked;
    route_e            route;

    incr_stage_xform #(
        .DATA_W (DATA_W),
        .STEP   (STEP)
    ) u_xform (
        .din  (in_data),
        .dout (result)
    );

    incr_stage_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .route     (route)
    );

    incr_stage_park_reg #(
        .DATA_W (DATA_W)
    ) u_park (
        .clk  (clk),
        .load (route == ROUTE_PARK),
        .din  (result),
        .dout (parked)
    );

    // Purpose: output valid flag, set on load, cleared when drained.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else if (route == ROUTE_DIRECT || route == ROUTE_FLUSH) begin
            out_valid <= 1'b1;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // Purpose: output data, loaded from the transform or the parked word.
    always_ff @(posedge clk) begin
        if (route == ROUTE_DIRECT) begin
            out_data <= result;
        end else if (route == ROUTE_FLUSH) begin
            out_data <= parked;
        end
    end

endmodule

// File: rtl/incr_skid_stage_checker.sv
// Module: protocol checker for incr_skid_stage, attached by bind.
// Assumes: inputs are known at every rising edge after reset.
module incr_skid_stage_checker #(
    parameter int DATA_W = 16,
    parameter int STEP   = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data
);

    localparam logic [DATA_W-1:0] STEP_V = DATA_W'(STEP);

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && in_ready));

    assert_direct_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (!out_valid || out_ready))
        |=> (out_valid && out_data == $past(in_data) + STEP_V));

    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_park_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && out_valid && !out_ready) |=> !in_ready);

    assert_flush_reopens_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && out_ready) |=> (in_ready && out_valid));

    assert_parked_means_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> out_valid);

    assert_streaming_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && out_ready) |=> in_ready);

    assert_drain_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && in_ready && !in_valid) |=> !out_valid);

endmodule

bind incr_skid_stage incr_skid_stage_checker #(
    .DATA_W (DATA_W),
    .STEP   (STEP)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/incr_skid_stage_bench.sv
// Bench: a vector table walked cycle by cycle, then directed reset
// and corner cases. Inputs change on the falling edge; outputs are
// sampled 1 ns after the rising edge.
module incr_skid_stage_bench;

    localparam int DW = 16;
    localparam int NV = 14;

    // Row: {req(4), in_valid, in_data(16), out_ready, exp_valid, exp_data(16), exp_ready}
    localparam int RW = 4 + 1 + DW + 1 + 1 + DW + 1;

    localparam logic [RW-1:0] VEC [NV] = '{
        {4'd3,  1'b1, 16'h0010, 1'b1, 1'b1, 16'h0011, 1'b1}, // R3 direct
        {4'd9,  1'b1, 16'h0020, 1'b1, 1'b1, 16'h0021, 1'b1}, // R9 stream
        {4'd9,  1'b1, 16'h0030, 1'b1, 1'b1, 16'h0031, 1'b1}, // R9 stream
        {4'd4,  1'b1, 16'hFFFF, 1'b1, 1'b1, 16'h0000, 1'b1}, // R4 wrap
        {4'd6,  1'b1, 16'h0100, 1'b0, 1'b1, 16'h0000, 1'b0}, // R6 park 0101
        {4'd2,  1'b1, 16'h0200, 1'b0, 1'b1, 16'h0000, 1'b0}, // R2 refused, R5 hold
        {4'd7,  1'b1, 16'h0300, 1'b1, 1'b1, 16'h0101, 1'b1}, // R7 flush, 0300 refused
        {4'd8,  1'b1, 16'h0400, 1'b1, 1'b1, 16'h0401, 1'b1}, // R8 direct after flush
        {4'd10, 1'b0, 16'h0500, 1'b1, 1'b0, 16'h0000, 1'b1}, // R10 drain
        {4'd3,  1'b1, 16'h1234, 1'b0, 1'b1, 16'h1235, 1'b1}, // R3 empty output
        {4'd5,  1'b0, 16'h0000, 1'b0, 1'b1, 16'h1235, 1'b1}, // R5 hold
        {4'd6,  1'b1, 16'h7FFF, 1'b0, 1'b1, 16'h1235, 1'b0}, // R6 park 8000
        {4'd7,  1'b0, 16'h0000, 1'b1, 1'b1, 16'h8000, 1'b1}, // R7 flush
        {4'd10, 1'b0, 16'h0000, 1'b1, 1'b0, 16'h0000, 1'b1}  // R10 drain
    };

    logic          clk;
    logic          rst_n;
    logic          in_valid;
    logic          in_ready;
    logic [DW-1:0] in_data;
    logic          out_valid;
    logic          out_ready;
    logic [DW-1:0] out_data;

    int checks;
    int errors;

    incr_skid_stage u_incr_skid_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic drive(input logic v, input logic [DW-1:0] d, input logic r);
        @(negedge clk);
        in_valid  = v;
        in_data   = d;
        out_ready = r;
        @(posedge clk);
        #1;
    endtask

    task automatic check_out(input int req, input logic ev, input logic [DW-1:0] ed,
                             input logic er, input logic cmp_data);
        checks++;
        if (out_valid !== ev || in_ready !== er || (cmp_data && out_data !== ed)) begin
            errors++;
            $display("FAIL R%0d: valid=%0b data=%h ready=%0b, expected valid=%0b data=%h ready=%0b",
                     req, out_valid, out_data, in_ready, ev, ed, er);
        end
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        checks    = 0;
        errors    = 0;
        rst_n     = 1'b0;
        in_valid  = 1'b0;
        in_data   = '0;
        out_ready = 1'b0;
        @(posedge clk);
        #1;
        // R1: state after reset
        check_out(1, 1'b0, '0, 1'b1, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [RW-1:0] row;
            row = VEC[i];
            drive(row[RW-5], row[RW-6 -: DW], row[DW+2]);
            check_out(int'(row[RW-1 -: 4]), row[DW+1], row[DW:1], row[0], row[DW+1]);
        end

        // R1: reset while a word is parked discards it
        drive(1'b1, 16'h0A00, 1'b0);
        check_out(3, 1'b1, 16'h0A01, 1'b1, 1'b1);
        drive(1'b1, 16'h0B00, 1'b0);
        check_out(6, 1'b1, 16'h0A01, 1'b0, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check_out(1, 1'b0, '0, 1'b1, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: no stale parked word appears afterwards
        drive(1'b0, 16'h0000, 1'b1);
        check_out(1, 1'b0, '0, 1'b1, 1'b0);

        // R2: valid without ready downstream of a parked word is ignored
        drive(1'b1, 16'h00FE, 1'b0);
        check_out(3, 1'b1, 16'h00FF, 1'b1, 1'b1);
        drive(1'b1, 16'h0010, 1'b0);
        check_out(6, 1'b1, 16'h00FF, 1'b0, 1'b1);
        drive(1'b1, 16'h0EEE, 1'b0);
        check_out(2, 1'b1, 16'h00FF, 1'b0, 1'b1);
        drive(1'b1, 16'h0EEE, 1'b1);
        check_out(7, 1'b1, 16'h0011, 1'b1, 1'b1);
        // R8: input right after flush flows directly, then drain
        drive(1'b1, 16'hFFFE, 1'b1);
        check_out(8, 1'b1, 16'hFFFF, 1'b1, 1'b1);
        drive(1'b0, 16'h0000, 1'b1);
        check_out(10, 1'b0, '0, 1'b1, 1'b0);

        // R9: long back-to-back run with downstream ready high
        for (int k = 0; k < 20; k++) begin
            logic [DW-1:0] d;
            d = DW'(k * 16'h0111);
            drive(1'b1, d, 1'b1);
            check_out(9, 1'b1, d + 16'd1, 1'b1, 1'b1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule